// File: doc/BRIEF.md
# Compact 16-bit-instruction processor core

A multi-cycle processor core that fetches 16-bit instructions from one little-endian memory port and executes them against sixteen 32-bit registers. Index 12 is a read-only status word, 13 is the stack pointer, 14 receives return addresses and 15 is the program counter. The opcode width varies with a prefix: a plain 4-bit opcode, an 8-bit opcode after the `1110` nibble and a 10-bit opcode after the `111100` prefix. All three share one 16-bit word.

Every instruction takes a fetch cycle and an execute cycle. Loads and stores use the same port in their execute cycle, and byte enables mark the active lanes. Branches are register-indirect and conditional on the signed flags. They can also deposit the return address in register 14. An undefined encoding records failure code 1 and parks the core for good. Only a reset brings it back.

Top module: `mini16_core`

## Requirements
- R1: Reset clears all registers, the flags and the failure code. The first request after reset is a read of address 0 with halted_o low.
- R2: Encodings with bits[15:12] in 0..10 hold a 4-bit opcode with Rx in bits[11:8]. The operands are either bits[7:0] as a constant or Ry in bits[7:4] and Rz in bits[3:0]. The opcodes are: 0 Rx+=k, 1 Rx=Ry+Rz, 2 Rx-=k, 3 Rx=Ry-Rz, 4 Rx=k, 5 Ry<<Rz, 6 Ry>>Rz (logical, a count of 32 or more gives 0), 7 or, 8 and, 9 Rx=~Ry, 10 xor.
- R3: The 8-bit constant is zero-extended before use.
- R4: Register 12 reads as {equal[31], negative[30], carry[29], overflow[28], zero[27:8], failure code[7:0]}. Ops 0-3 and compare update the four flags. Carry is the carry-out on add and no-borrow on subtract. Overflow is the signed overflow. Logic, shift, move, constant-write and memory ops leave the flags unchanged.
- R5: An instruction that names register 12 as its destination leaves register 12 unchanged.
- R6: Bits[15:11] = 11100 select an 8-bit op with Rx in bits[7:4] and Ry in bits[3:0]. Bits[10:8] select the op: 0 Rx=Ry, 1 word load, 2 word store, 3 halfword load, 4 halfword store, 5 byte load, 6 byte store, 7 compare. Compare computes Rx-Ry and writes no register.
- R7: Loads read from address Ry in little-endian order and zero-extend into Rx. A halfword load ignores address bit 0.
- R8: Stores write Rx to address Ry. A word store enables all four lanes. A halfword store writes only Rx[15:0] to lanes 1:0 or 3:2, chosen by address bit 1. A byte store writes only Rx[7:0] to the lane given by address bits[1:0].
- R9: Bits[15:6] = 111100,cond select a branch to the full value of Rx in bits[3:0]. The conditions are 0 always, 1 equal, 2 not equal, 3 signed greater, 4 signed greater-or-equal, 5 signed less, 6 signed less-or-equal.
- R10: When bit 5 is set on a taken branch, register 14 receives the branch address plus 2. A branch that is not taken, or one with bit 5 clear, leaves register 14 unchanged.
- R11: The program counter advances by 2 after each instruction. A taken branch or a write to register 15 redirects it. Register 15 reads as the address of the executing instruction.
- R12: Top nibbles 11, 12 and 13, an 8-bit prefix with bit 11 set, and a branch prefix with bits[11:10] nonzero or cond above 6 are all illegal. Any of them sets the failure code to 1 and raises halted_o, and the core then makes no further memory requests.
- R13: Each instruction takes two cycles: a fetch read, then execution. A program of N legal instructions followed by an illegal one raises halted_o 2N+2 clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_be_o | output | 4 | Byte lane enables for writes |
| mem_wdata_o | output | 32 | Write data, lane-replicated for narrow stores |
| mem_rdata_i | input | 32 | Read data, valid in the cycle of the request |
| halted_o | output | 1 | Core stopped on an illegal encoding |

## Verification
On every cycle the assertions check that fetch and execute alternate and that fetch is a pure read. They also check that store lane enables form a legal word, halfword or byte pattern, and that without a redirect the program counter steps by 2. Once halted, the core must stay halted with failure code 1 and issue no request. The arithmetic results, the exact flag values and the signed branch decisions can only be shown by the scenarios, as can link writes, little-endian lane selection and the refusal to write register 12. The bench reads all of these back through stores to memory.

// File: rtl/mini16_pkg.sv
package mini16_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 16;
  localparam int RIDX = $clog2(NREG);
  localparam int IMMW = 8;
  localparam logic [RIDX-1:0] STATUS_IDX = 4'd12;
  localparam logic [RIDX-1:0] LINK_IDX   = 4'd14;
  localparam logic [RIDX-1:0] PC_IDX     = 4'd15;

  typedef enum logic [2:0] {K_ALU, K_CMP, K_LD, K_ST, K_BR, K_ILL} kind_e;
  typedef enum logic [3:0] {
    A_ADD, A_SUB, A_SHL, A_SHR, A_OR, A_AND, A_NOT, A_XOR, A_PASS
  } alu_e;
  typedef enum logic [1:0] {SZ_W, SZ_H, SZ_B} size_e;

  typedef struct packed {
    logic eq;
    logic neg;
    logic cy;
    logic ov;
  } flags_t;

  typedef struct packed {
    kind_e          kind;
    alu_e           alu;
    size_e          size;
    logic [RIDX-1:0] rd;
    logic [RIDX-1:0] ra;
    logic [RIDX-1:0] rb;
    logic           use_imm;
    logic [IMMW-1:0] imm;
    logic           set_flags;
    logic [3:0]     cond;
    logic           link;
  } dec_t;
endpackage

// File: rtl/mini16_decode.sv
module mini16_decode
  import mini16_pkg::*;
(
  input  logic [15:0] instr_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o           = '0;
    dec_o.kind      = K_ILL;
    dec_o.alu       = A_PASS;
    dec_o.size      = SZ_W;
    dec_o.imm       = instr_i[7:0];
    if (instr_i[15:12] <= 4'hA) begin
      dec_o.kind = K_ALU;
      dec_o.rd   = instr_i[11:8];
      dec_o.ra   = instr_i[7:4];
      dec_o.rb   = instr_i[3:0];
      unique case (instr_i[15:12])
        4'h0: begin dec_o.alu = A_ADD; dec_o.ra = instr_i[11:8]; dec_o.use_imm = 1'b1; dec_o.set_flags = 1'b1; end
        4'h1: begin dec_o.alu = A_ADD; dec_o.set_flags = 1'b1; end
        4'h2: begin dec_o.alu = A_SUB; dec_o.ra = instr_i[11:8]; dec_o.use_imm = 1'b1; dec_o.set_flags = 1'b1; end
        4'h3: begin dec_o.alu = A_SUB; dec_o.set_flags = 1'b1; end
        4'h4: begin dec_o.alu = A_PASS; dec_o.use_imm = 1'b1; end
        4'h5: dec_o.alu = A_SHL;
        4'h6: dec_o.alu = A_SHR;
        4'h7: dec_o.alu = A_OR;
        4'h8: dec_o.alu = A_AND;
        4'h9: dec_o.alu = A_NOT;
        default: dec_o.alu = A_XOR;
      endcase
    end else if (instr_i[15:11] == 5'b11100) begin
      dec_o.rd = instr_i[7:4];
      dec_o.ra = instr_i[7:4];
      dec_o.rb = instr_i[3:0];
      unique case (instr_i[10:8])
        3'd0: dec_o.kind = K_ALU;
        3'd1: begin dec_o.kind = K_LD; dec_o.size = SZ_W; end
        3'd2: begin dec_o.kind = K_ST; dec_o.size = SZ_W; end
        3'd3: begin dec_o.kind = K_LD; dec_o.size = SZ_H; end
        3'd4: begin dec_o.kind = K_ST; dec_o.size = SZ_H; end
        3'd5: begin dec_o.kind = K_LD; dec_o.size = SZ_B; end
        3'd6: begin dec_o.kind = K_ST; dec_o.size = SZ_B; end
        default: begin dec_o.kind = K_CMP; dec_o.alu = A_SUB; dec_o.set_flags = 1'b1; end
      endcase
    end else if (instr_i[15:10] == 6'b111100 && instr_i[9:6] <= 4'd6) begin
      dec_o.kind = K_BR;
      dec_o.cond = instr_i[9:6];
      dec_o.link = instr_i[5];
      dec_o.rb   = instr_i[3:0];
    end
  end
endmodule

// File: rtl/mini16_alu.sv
module mini16_alu
  import mini16_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_e         op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output flags_t       f_o
);
  logic [W:0] sum, dif;

  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    dif = {1'b0, a_i} - {1'b0, b_i};
    unique case (op_i)
      A_ADD:   y_o = sum[W-1:0];
      A_SUB:   y_o = dif[W-1:0];
      A_SHL:   y_o = a_i << b_i;
      A_SHR:   y_o = a_i >> b_i;
      A_OR:    y_o = a_i | b_i;
      A_AND:   y_o = a_i & b_i;
      A_NOT:   y_o = ~a_i;
      A_XOR:   y_o = a_i ^ b_i;
      default: y_o = b_i;
    endcase
    f_o.eq  = (y_o == '0);
    f_o.neg = y_o[W-1];
    if (op_i == A_SUB) begin
      f_o.cy = ~dif[W];
      f_o.ov = (a_i[W-1] != b_i[W-1]) && (y_o[W-1] != a_i[W-1]);
    end else begin
      f_o.cy = sum[W];
      f_o.ov = (a_i[W-1] == b_i[W-1]) && (y_o[W-1] != a_i[W-1]);
    end
  end
endmodule

// File: rtl/mini16_regfile.sv
module mini16_regfile
  import mini16_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREG,
  parameter logic [N-1:0] HOLE_MASK = '0,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (HOLE_MASK[i]) begin : g_hole
      assign regs[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                regs[i] <= '0;
        else if (we_i && waddr_i == AW'(i))          regs[i] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/mini16_core.sv
module mini16_core
  import mini16_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [3:0]      mem_be_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            halted_o
);
  localparam logic [NREG-1:0] HOLES = (NREG'(1) << STATUS_IDX) | (NREG'(1) << PC_IDX);

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_HALT} state_e;

  state_e          state_q;
  logic [15:0]     ir_q;
  logic [XLEN-1:0] pc_q;
  flags_t          flags_q;
  logic [7:0]      fail_q;

  dec_t            dec;
  logic [XLEN-1:0] rf_a, rf_b, ra_val, rb_val, opb, alu_y, status_w;
  flags_t          alu_f;
  logic            in_fetch, in_exec, cond_ok, br_taken, redirect;
  logic            wr_en;
  logic [RIDX-1:0] wr_idx;
  logic [XLEN-1:0] wr_data, eff_addr, ld_data, lane_data, pc_next;

  assign in_fetch = (state_q == S_FETCH);
  assign in_exec  = (state_q == S_EXEC);
  assign halted_o = (state_q == S_HALT);

  mini16_decode u_dec (.instr_i(ir_q), .dec_o(dec));

  mini16_regfile #(.HOLE_MASK(HOLES)) u_rf (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(wr_idx), .wdata_i(wr_data),
    .raddr_a_i(dec.ra), .rdata_a_o(rf_a),
    .raddr_b_i(dec.rb), .rdata_b_o(rf_b)
  );

  assign status_w = {flags_q, {(XLEN-12){1'b0}}, fail_q};
  assign ra_val = (dec.ra == STATUS_IDX) ? status_w : (dec.ra == PC_IDX) ? pc_q : rf_a;
  assign rb_val = (dec.rb == STATUS_IDX) ? status_w : (dec.rb == PC_IDX) ? pc_q : rf_b;
  assign opb    = dec.use_imm ? {{(XLEN-IMMW){1'b0}}, dec.imm} : rb_val;

  mini16_alu u_alu (.op_i(dec.alu), .a_i(ra_val), .b_i(opb), .y_o(alu_y), .f_o(alu_f));

  // signed conditions from the flags of the last add/sub/compare
  always_comb begin
    unique case (dec.cond)
      4'd0:    cond_ok = 1'b1;
      4'd1:    cond_ok = flags_q.eq;
      4'd2:    cond_ok = !flags_q.eq;
      4'd3:    cond_ok = !flags_q.eq && (flags_q.neg == flags_q.ov);
      4'd4:    cond_ok = (flags_q.neg == flags_q.ov);
      4'd5:    cond_ok = (flags_q.neg != flags_q.ov);
      4'd6:    cond_ok = flags_q.eq || (flags_q.neg != flags_q.ov);
      default: cond_ok = 1'b0;
    endcase
  end
  assign br_taken = in_exec && dec.kind == K_BR && cond_ok;

  // memory port
  assign eff_addr    = (in_exec && (dec.kind == K_LD || dec.kind == K_ST)) ? rb_val : pc_q;
  assign mem_req_o   = in_fetch || (in_exec && (dec.kind == K_LD || dec.kind == K_ST));
  assign mem_we_o    = in_exec && dec.kind == K_ST;
  assign mem_addr_o  = {eff_addr[XLEN-1:2], 2'b00};
  assign lane_data   = mem_rdata_i >> {eff_addr[1:0], 3'b000};

  always_comb begin
    mem_be_o    = 4'b0000;
    mem_wdata_o = ra_val;
    ld_data     = mem_rdata_i;
    unique case (dec.size)
      SZ_H: begin
        mem_wdata_o = {2{ra_val[15:0]}};
        ld_data     = {16'b0, eff_addr[1] ? mem_rdata_i[31:16] : mem_rdata_i[15:0]};
        if (mem_we_o) mem_be_o = eff_addr[1] ? 4'b1100 : 4'b0011;
      end
      SZ_B: begin
        mem_wdata_o = {4{ra_val[7:0]}};
        ld_data     = {24'b0, lane_data[7:0]};
        if (mem_we_o) mem_be_o = 4'b0001 << eff_addr[1:0];
      end
      default: if (mem_we_o) mem_be_o = 4'b1111;
    endcase
  end

  // write-back
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = dec.rd;
    wr_data = alu_y;
    if (in_exec) begin
      unique case (dec.kind)
        K_ALU: wr_en = 1'b1;
        K_LD:  begin wr_en = 1'b1; wr_data = ld_data; end
        K_BR:  begin wr_en = br_taken && dec.link; wr_idx = LINK_IDX; wr_data = pc_q + XLEN'(2); end
        default: wr_en = 1'b0;
      endcase
    end
  end

  assign redirect = br_taken || (wr_en && wr_idx == PC_IDX);
  assign pc_next  = br_taken ? rb_val : (wr_en && wr_idx == PC_IDX) ? wr_data : pc_q + XLEN'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      ir_q    <= '0;
      pc_q    <= '0;
      flags_q <= '0;
      fail_q  <= '0;
    end else begin
      unique case (state_q)
        S_FETCH: begin
          ir_q    <= pc_q[1] ? mem_rdata_i[31:16] : mem_rdata_i[15:0];
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          if (dec.kind == K_ILL) begin
            fail_q  <= 8'd1;
            state_q <= S_HALT;
          end else begin
            if (dec.set_flags) flags_q <= alu_f;
            pc_q    <= pc_next;
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/mini16_core_chk.sv
module mini16_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_i,
  input logic        mem_we_i,
  input logic [3:0]  mem_be_i,
  input logic        halted_i,
  input logic        in_fetch_i,
  input logic        in_exec_i,
  input logic        redirect_i,
  input logic [31:0] pc_i,
  input logic [7:0]  fail_i
);
  p_store_lanes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> mem_req_i && (mem_be_i == 4'b1111 || mem_be_i == 4'b0011 ||
                               mem_be_i == 4'b1100 || $countones(mem_be_i) == 1));

  p_fetch_read_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fetch_i |-> mem_req_i && !mem_we_i && mem_be_i == 4'b0000);

  p_fetch_then_exec_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fetch_i |=> in_exec_i);

  p_exec_then_leave_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_exec_i |=> !in_exec_i);

  p_pc_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_exec_i && !redirect_i |=> halted_i || pc_i == $past(pc_i) + 32'd2);

  p_halt_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i && !mem_req_i);

  p_fail_code_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> fail_i == 8'd1);
endmodule

bind mini16_core mini16_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_i  (mem_req_o),
  .mem_we_i   (mem_we_o),
  .mem_be_i   (mem_be_o),
  .halted_i   (halted_o),
  .in_fetch_i (in_fetch),
  .in_exec_i  (in_exec),
  .redirect_i (redirect),
  .pc_i       (pc_q),
  .fail_i     (fail_q)
);

// File: tb/mini16_core_tb_top.sv
module mini16_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_req, mem_we, halted;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] mem [128];
  logic [31:0] img [128];
  logic        h_we = 1'b0;
  logic [6:0]  h_idx = '0;
  logic [31:0] h_dat = '0;

  int n_checks = 0;
  int n_errors = 0;
  int halt_req = 0;
  int ptr = 0;

  always #2 clk = ~clk;

  mini16_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .halted_o(halted)
  );

  assign mem_rdata = mem[mem_addr[8:2]];

  always @(posedge clk) begin
    if (h_we) mem[h_idx] <= h_dat;
    else if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[8:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  always @(negedge clk) if (rst_ni && halted && mem_req) halt_req++;

  // encoders
  function automatic logic [15:0] ri(input logic [3:0] op, input logic [3:0] x, input logic [7:0] k);
    return {op, x, k};
  endfunction
  function automatic logic [15:0] rr(input logic [3:0] op, input logic [3:0] x, input logic [3:0] y, input logic [3:0] z);
    return {op, x, y, z};
  endfunction
  function automatic logic [15:0] e8(input logic [2:0] sub, input logic [3:0] x, input logic [3:0] y);
    return {5'b11100, sub, x, y};
  endfunction
  function automatic logic [15:0] br(input logic [3:0] c, input logic lnk, input logic [3:0] x);
    return {6'b111100, c, lnk, 1'b0, x};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input int addr, input logic [31:0] exp);
    chk(mem[addr >> 2] === exp, req, mem[addr >> 2], exp);
  endtask

  task automatic new_prog();
    for (int i = 0; i < 128; i++) img[i] = 32'h0;
    ptr = 0;
  endtask

  task automatic put(input logic [15:0] h);
    if (ptr[1]) img[ptr >> 2][31:16] = h;
    else        img[ptr >> 2][15:0]  = h;
    ptr += 2;
  endtask

  task automatic ldi(input logic [3:0] x, input int k);
    put(ri(4'h4, x, 8'(k)));
  endtask

  task automatic st_at(input logic [3:0] r, input int addr);
    ldi(4'd11, addr);
    put(e8(3'd2, r, 4'd11));
  endtask

  task automatic load_reset();
    rst_ni = 1'b0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      h_we = 1'b1; h_idx = 7'(i); h_dat = img[i];
    end
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic go(output int cyc);
    halt_req = 0;
    rst_ni = 1'b1;
    cyc = 0;
    while (!halted && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 4000, "R12 watchdog: halt reached", cyc, 0);
    repeat (4) @(negedge clk);
    chk(halt_req == 0, "R12 no request after halt", halt_req, 0);
  endtask

  task automatic t_reset();
    int cyc;
    new_prog();
    img[8'hC0 >> 2] = 32'hFFFF_FFFF;
    img[8'hC4 >> 2] = 32'hFFFF_FFFF;
    st_at(4'd0, 8'hC0);
    st_at(4'd5, 8'hC4);
    put(16'hB000);
    load_reset();
    chk(mem_req === 1'b1 && mem_we === 1'b0, "R1 fetch request in reset", {mem_req, mem_we}, 32'h2);
    chk(mem_addr === 32'h0, "R1 fetch address zero", mem_addr, 32'h0);
    chk(halted === 1'b0, "R1 halted low", halted, 0);
    go(cyc);
    chk_word("R1 r0 cleared", 8'hC0, 32'h0);
    chk_word("R1 r5 cleared", 8'hC4, 32'h0);
  endtask

  task automatic t_arith();
    int cyc;
    new_prog();
    ldi(1, 200); ldi(2, 100);
    put(rr(4'h1, 3, 1, 2));
    put(rr(4'h3, 4, 2, 1));
    put(ri(4'h0, 1, 8'hFF));
    put(ri(4'h2, 2, 8'h01));
    st_at(3, 8'hC0); st_at(4, 8'hC4); st_at(1, 8'hC8); st_at(2, 8'hCC);
    put(16'hB000);
    load_reset(); go(cyc);
    chk_word("R2 add", 8'hC0, 32'd300);
    chk_word("R2 sub negative", 8'hC4, 32'hFFFF_FF9C);
    chk_word("R3 add constant 0xFF zero-extended", 8'hC8, 32'd455);
    chk_word("R3 subtract constant", 8'hCC, 32'd99);
  endtask

  task automatic t_logic();
    int cyc;
    new_prog();
    ldi(1, 8'hF0); ldi(2, 8'h3C); ldi(7, 4); ldi(10, 40);
    put(rr(4'h7, 3, 1, 2));
    put(rr(4'h8, 4, 1, 2));
    put(rr(4'hA, 5, 1, 2));
    put(rr(4'h9, 6, 1, 0));
    put(rr(4'h5, 8, 1, 7));
    put(rr(4'h6, 9, 1, 7));
    put(rr(4'h5, 10, 1, 10));
    st_at(3, 8'hC0); st_at(4, 8'hC4); st_at(5, 8'hC8); st_at(6, 8'hCC);
    st_at(8, 8'hD0); st_at(9, 8'hD4); st_at(10, 8'hD8);
    put(16'hB000);
    load_reset(); go(cyc);
    chk_word("R2 or", 8'hC0, 32'hFC);
    chk_word("R2 and", 8'hC4, 32'h30);
    chk_word("R2 xor", 8'hC8, 32'hCC);
    chk_word("R2 flip", 8'hCC, 32'hFFFF_FF0F);
    chk_word("R2 shift left", 8'hD0, 32'hF00);
    chk_word("R2 shift right", 8'hD4, 32'h0F);
    chk_word("R2 shift by 40", 8'hD8, 32'h0);
  endtask

  task automatic t_flags();
    int cyc;
    new_prog();
    ldi(1, 5); ldi(2, 5);
    put(e8(3'd7, 1, 2));
    put(e8(3'd0, 3, 12)); st_at(3, 8'hC0); st_at(1, 8'hC4);
    ldi(4, 7);
    put(e8(3'd7, 1, 4));
    put(e8(3'd0, 3, 12)); st_at(3, 8'hC8);
    put(rr(4'h7, 5, 1, 4));
    put(e8(3'd0, 3, 12)); st_at(3, 8'hCC);
    ldi(1, 1); ldi(2, 31);
    put(rr(4'h5, 1, 1, 2));
    put(ri(4'h2, 1, 8'h01));
    put(ri(4'h0, 1, 8'h01));
    put(e8(3'd0, 3, 12)); st_at(3, 8'hD0);
    put(rr(4'h9, 6, 0, 0));
    put(ri(4'h0, 6, 8'h01));
    put(e8(3'd0, 3, 12)); st_at(3, 8'hD4);
    ldi(12, 8'h55);
    put(e8(3'd0, 3, 12)); st_at(3, 8'hD8);
    put(16'hB000);
    load_reset(); go(cyc);
    chk_word("R4 compare equal flags", 8'hC0, 32'hA000_0000);
    chk_word("R6 compare leaves Rx", 8'hC4, 32'd5);
    chk_word("R4 compare negative flags", 8'hC8, 32'h4000_0000);
    chk_word("R4 logic keeps flags", 8'hCC, 32'h4000_0000);
    chk_word("R4 add overflow flags", 8'hD0, 32'h5000_0000);
    chk_word("R4 add carry-out flags", 8'hD4, 32'hA000_0000);
    chk_word("R5 write to r12 ignored", 8'hD8, 32'hA000_0000);
  endtask

  task automatic t_loads();
    int cyc;
    new_prog();
    img[8'hE0 >> 2] = 32'h8899_AABB;
    img[8'hE4 >> 2] = 32'h1122_3344;
    ldi(1, 8'hE0); put(e8(3'd1, 2, 1));
    ldi(1, 8'hE2); put(e8(3'd3, 3, 1));
    ldi(1, 8'hE3); put(e8(3'd3, 4, 1));
    ldi(1, 8'hE1); put(e8(3'd5, 5, 1));
    ldi(1, 8'hE7); put(e8(3'd5, 6, 1));
    ldi(1, 8'hE4); put(e8(3'd3, 7, 1));
    st_at(2, 8'hC0); st_at(3, 8'hC4); st_at(4, 8'hC8);
    st_at(5, 8'hCC); st_at(6, 8'hD0); st_at(7, 8'hD4);
    put(16'hB000);
    load_reset(); go(cyc);
    chk_word("R7 word load", 8'hC0, 32'h8899_AABB);
    chk_word("R7 upper halfword load", 8'hC4, 32'h0000_8899);
    chk_word("R7 halfword ignores bit 0", 8'hC8, 32'h0000_8899);
    chk_word("R7 byte load lane 1", 8'hCC, 32'h0000_00AA);
    chk_word("R7 byte load lane 3", 8'hD0, 32'h0000_0011);
    chk_word("R7 lower halfword load", 8'hD4, 32'h0000_3344);
  endtask

  task automatic t_stores();
    int cyc;
    new_prog();
    for (int a = 8'hC0; a <= 8'hD0; a += 4) img[a >> 2] = 32'hDEAD_BEEF;
    ldi(1, 8'h12); ldi(2, 8);
    put(rr(4'h5, 1, 1, 2)); put(ri(4'h0, 1, 8'h34));
    put(rr(4'h5, 1, 1, 2)); put(ri(4'h0, 1, 8'h56));
    put(rr(4'h5, 1, 1, 2)); put(ri(4'h0, 1, 8'h78));
    st_at(1, 8'hC0);
    ldi(11, 8'hC6); put(e8(3'd4, 1, 11));
    ldi(11, 8'hC9); put(e8(3'd4, 1, 11));
    ldi(11, 8'hCF); put(e8(3'd6, 1, 11));
    ldi(11, 8'hD1); put(e8(3'd6, 1, 11));
    put(16'hB000);
    load_reset(); go(cyc);
    chk_word("R8 word store", 8'hC0, 32'h1234_5678);
    chk_word("R8 halfword store upper", 8'hC4, 32'h5678_BEEF);
    chk_word("R8 halfword store ignores bit 0", 8'hC8, 32'hDEAD_5678);
    chk_word("R8 byte store lane 3", 8'hCC, 32'h78AD_BEEF);
    chk_word("R8 byte store lane 1", 8'hD0, 32'hDEAD_78EF);
  endtask

  task automatic t_branches();
    int cyc;
    logic [3:0] ca [14] = '{1,1,1,1,1,2,1,1,1,3,3,1,1,2};
    logic [3:0] cb [14] = '{2,4,2,2,4,1,4,3,4,1,1,4,4,1};
    logic [3:0] cc [14] = '{0,1,1,2,2,3,3,3,4,4,5,5,6,6};
    bit         tk [14] = '{1,1,0,1,0,1,0,1,1,0,1,0,1,0};
    new_prog();
    ldi(10, 1); ldi(8, 8); put(rr(4'h5, 10, 10, 8));
    ldi(1, 5); ldi(2, 7); put(rr(4'h9, 3, 0, 0)); ldi(4, 5);
    for (int k = 0; k < 14; k++) begin
      ldi(6, 0);
      put(e8(3'd7, ca[k], cb[k]));
      ldi(9, ptr + 6);
      put(br(cc[k], 1'b0, 9));
      ldi(6, 1);
      put(e8(3'd2, 6, 10));
      put(ri(4'h0, 10, 8'h04));
    end
    put(16'hB000);
    load_reset(); go(cyc);
    for (int k = 0; k < 14; k++)
      chk_word($sformatf("R9 branch case %0d cond %0d", k, cc[k]), 32'h100 + 4 * k,
               tk[k] ? 32'd0 : 32'd1);
  endtask

  task automatic t_link_pc();
    int cyc, a1, a5, t;
    new_prog();
    ldi(14, 0);
    t = ptr + 6; ldi(9, t); a1 = ptr; put(br(4'd0, 1'b1, 9)); ldi(14, 8'h77);
    st_at(14, 8'hC0);
    ldi(14, 8'h33);
    t = ptr + 6; ldi(9, t); put(br(4'd0, 1'b0, 9)); ldi(14, 8'h44);
    st_at(14, 8'hC4);
    ldi(1, 1); put(e8(3'd7, 1, 1));
    t = ptr + 6; ldi(9, t); put(br(4'd2, 1'b1, 9)); ldi(5, 0);
    st_at(14, 8'hC8);
    t = ptr + 4; ldi(15, t); ldi(14, 8'h55);
    st_at(14, 8'hCC);
    a5 = ptr; put(e8(3'd0, 7, 15));
    st_at(7, 8'hD0);
    put(16'hB000);
    load_reset(); go(cyc);
    chk_word("R10 link on taken branch", 8'hC0, 32'(a1 + 2));
    chk_word("R10 no link when bit 5 clear", 8'hC4, 32'h33);
    chk_word("R10 no link when not taken", 8'hC8, 32'h33);
    chk_word("R11 write to r15 redirects", 8'hCC, 32'h33);
    chk_word("R11 r15 reads current address", 8'hD0, 32'(a5));
  endtask

  task automatic t_illegal();
    logic [15:0] bad [6] = '{16'hB123, 16'hC000, 16'hD000, 16'hE800, 16'hF400, 16'hF1C0};
    for (int i = 0; i < 6; i++) begin
      int cyc;
      new_prog();
      img[8'hC4 >> 2] = 32'hFFFF_FFFF;
      ldi(1, 7); ldi(11, 8'hC0); put(e8(3'd2, 1, 11));
      put(bad[i]);
      st_at(1, 8'hC4);
      load_reset(); go(cyc);
      chk(halted === 1'b1, $sformatf("R12 halted on 0x%04h", bad[i]), halted, 1);
      chk_word("R12 instructions before illegal ran", 8'hC0, 32'd7);
      chk_word("R12 nothing after illegal", 8'hC4, 32'hFFFF_FFFF);
      chk(cyc == 8, "R13 two cycles per instruction", cyc, 8);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_flags();
    t_loads();
    t_stores();
    t_branches();
    t_link_pc();
    t_illegal();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule